// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is the command decoder and write-automation sequencer of a small byte-wide flash memory split into four equally sized erase blocks, one of which holds boot code. A processor bus, already sampled into the block's clock domain, delivers address, data, an active-low write strobe and an active-low output enable. A write takes effect on the clock where the strobe is seen rising (low to high), using the address and data present on that clock. The block turns these writes into command sequences. It times program and erase operations with counters, and drives one-cycle program and erase pulses toward an external behavioural cell array. Reads are served from the array, from an 8-bit status register, or from a two-byte identifier.

The sequencer has six states. S_IDLE decodes single-write commands. A program-setup byte moves it to S_PSETUP, and an erase-setup byte moves it to S_ESETUP. The next write either starts S_PBUSY or S_EBUSY, or returns to S_IDLE with an error flag set. A busy state returns to S_IDLE when its counter runs out, and at that point the array pulse is issued. The suspend byte moves S_EBUSY to S_ESUSP, and the confirm byte moves S_ESUSP back to S_EBUSY with the counter value kept. A separate read-mode register selects array, status or identifier reads.

Status bits are: bit 7 ready (1 = idle or suspended, 0 = operation running), bit 6 erase suspended, bit 5 erase error, bit 4 program error, and bits 3..0 always zero. The block number is the top two address bits. The boot block is number `BOOT_BLK` (default 3). It can be modified only while `boot_unlock` is high at the write that commits the operation.

Top module: `flash_cmd_fsm`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the block is in array-read mode with status 8'h80 and no array pulse, so a read returns `arr_rdata`.
- R2: In S_IDLE or S_ESUSP, a write of FFh selects array reads, 70h selects status reads, and 90h selects identifier reads (address bit 0 = 0 gives `MFR_CODE`, 1 gives `DEV_CODE`). With `oe_n` high, `rdata` is 8'h00.
- R3: A write of 40h followed by a write of (A, D) to an unlocked block leads to exactly one `arr_prog` pulse, one cycle wide, carrying A and D. The pulse comes `PROG_CYC` cycles after the clock that accepted the second write.
- R4: Once a program or erase command is accepted, reads return status. Bit 7 is 0 for exactly the busy duration and becomes 1 on the cycle the array pulse is high.
- R5: A write of 20h followed by D0h at an address in an unlocked block leads to exactly one `arr_erase` pulse carrying that address, `ERASE_CYC` busy cycles after the confirm write (time spent suspended not counted).
- R6: If a byte other than D0h follows 20h, the block sets the erase-error bit (bit 5), issues no erase, and returns to ready with status reads selected.
- R7: While `boot_unlock` is low, a program to the boot block sets bit 4 and an erase confirm sets bit 5. Neither produces an array pulse. With `boot_unlock` high, both proceed normally.
- R8: B0h during an erase enters suspend: bit 7 = 1, bit 6 = 1, and the counter is frozen. Array and identifier reads are allowed while suspended. D0h resumes the erase, which then runs its remaining cycles.
- R9: A write of 50h clears bits 5 and 4 and leaves the read mode unchanged.
- R10: Asserting `rst_n` during an operation aborts it, and no array pulse follows.
- R11: Writes during a program operation are ignored: the read mode, the captured address and the captured data all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low device reset; aborts any operation |
| boot_unlock | input | 1 | High permits program/erase of the boot block |
| addr | input | ADDR_W | Sampled bus address |
| wdata | input | 8 | Sampled bus write data |
| we_n | input | 1 | Sampled active-low write strobe; acts on its rising edge |
| oe_n | input | 1 | Sampled active-low output enable |
| arr_rdata | input | 8 | Array byte at `addr` from the behavioural array |
| rdata | output | 8 | Read data (array, status or identifier) |
| arr_addr | output | ADDR_W | Captured target address for the array pulse |
| arr_wdata | output | 8 | Captured program data |
| arr_prog | output | 1 | One-cycle program pulse |
| arr_erase | output | 1 | One-cycle block erase pulse |

## Verification
A command takes effect on the clock where the strobe is sampled high after being low. The read mode and status therefore change in the cycle after that clock, and `rdata` follows at once because the read mux is combinational. The program pulse appears `PROG_CYC` clocks after the accepting clock, and the erase pulse `ERASE_CYC` clocks after it, plus any cycles spent suspended. The pulse lands on the same clock where ready returns to 1, and the array content changes one clock later. The bench drives inputs on falling edges and samples every output just before the next rising edge. It compares them against a cycle-stepped reference model that applies these same latencies, and it adds directed checks with literal expected values at the points where each result is due.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_READ_ID      = 8'h90;
    localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;

    localparam int ST_READY = 7;
    localparam int ST_SUSP  = 6;
    localparam int ST_EERR  = 5;
    localparam int ST_PERR  = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PSETUP,
        S_ESETUP,
        S_PBUSY,
        S_EBUSY,
        S_ESUSP
    } op_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_ID
    } rd_mode_t;
endpackage

// File: rtl/flash_bus_sync.sv
`timescale 1ns/1ps
module flash_bus_sync #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    // strobe seen high now, low on the previous sample: rising edge
    assign wr_evt  = we_n & ~we_q;
    assign wr_addr = addr_in;
    assign wr_data = data_in;
endmodule

// File: rtl/flash_op_timer.sv
`timescale 1ns/1ps
module flash_op_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/flash_rd_mux.sv
`timescale 1ns/1ps
module flash_rd_mux
    import flash_cmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              oe_n,
    input  rd_mode_t          mode,
    input  logic              id_sel,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] sts,
    input  logic [DATA_W-1:0] mfr_code,
    input  logic [DATA_W-1:0] dev_code,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        if (oe_n) begin
            rdata = '0;
        end else begin
            unique case (mode)
                RM_ARRAY:  rdata = arr_rdata;
                RM_STATUS: rdata = sts;
                RM_ID:     rdata = id_sel ? dev_code : mfr_code;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         PROG_CYC  = 8,
    parameter int         ERASE_CYC = 40,
    parameter int         BOOT_BLK  = 3,
    parameter logic [7:0] MFR_CODE  = 8'hA7,
    parameter logic [7:0] DEV_CODE  = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_unlock,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              arr_prog,
    output logic              arr_erase
);
    localparam int DATA_W   = 8;
    localparam int BLK_BITS = 2;
    localparam int MAX_CYC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

    op_state_t         state;
    rd_mode_t          rd_mode;
    logic              perr, eerr;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;
    logic              wr_evt;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              tgt_locked, susp_req;
    logic [7:0]        sts;

    flash_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_n    (we_n),
        .addr_in (addr),
        .data_in (wdata),
        .wr_evt  (wr_evt),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flash_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    // control decode feeding the timer
    always_comb begin
        tgt_locked = (wr_addr[ADDR_W-1 -: BLK_BITS] == BLK_BITS'(BOOT_BLK)) && !boot_unlock;
        susp_req   = wr_evt && (wr_data == CMD_SUSPEND);
        tmr_load   = 1'b0;
        tmr_val    = '0;
        if (state == S_PSETUP && wr_evt && !tgt_locked) begin
            tmr_load = 1'b1;
            tmr_val  = PROG_LOAD;
        end else if (state == S_ESETUP && wr_evt && wr_data == CMD_CONFIRM && !tgt_locked) begin
            tmr_load = 1'b1;
            tmr_val  = ERASE_LOAD;
        end
        tmr_dec = (state == S_PBUSY) || (state == S_EBUSY && !susp_req);
    end

    // state register and command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            rd_mode  <= RM_ARRAY;
            perr     <= 1'b0;
            eerr     <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (wr_evt) begin
                        unique case (wr_data)
                            CMD_READ_ARRAY:   rd_mode <= RM_ARRAY;
                            CMD_READ_STATUS:  rd_mode <= RM_STATUS;
                            CMD_READ_ID:      rd_mode <= RM_ID;
                            CMD_CLEAR_STATUS: begin perr <= 1'b0; eerr <= 1'b0; end
                            CMD_PROG_SETUP:   state <= S_PSETUP;
                            CMD_ERASE_SETUP:  state <= S_ESETUP;
                            default: ;
                        endcase
                    end
                end
                S_PSETUP: begin
                    if (wr_evt) begin
                        rd_mode <= RM_STATUS;
                        if (tgt_locked) begin
                            perr  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            cap_addr <= wr_addr;
                            cap_data <= wr_data;
                            state    <= S_PBUSY;
                        end
                    end
                end
                S_ESETUP: begin
                    if (wr_evt) begin
                        rd_mode <= RM_STATUS;
                        if (wr_data != CMD_CONFIRM || tgt_locked) begin
                            eerr  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            cap_addr <= wr_addr;
                            state    <= S_EBUSY;
                        end
                    end
                end
                S_PBUSY: begin
                    if (tmr_zero) state <= S_IDLE;
                end
                S_EBUSY: begin
                    if (susp_req) begin
                        state   <= S_ESUSP;
                        rd_mode <= RM_STATUS;
                    end else if (tmr_zero) begin
                        state <= S_IDLE;
                    end
                end
                S_ESUSP: begin
                    if (wr_evt) begin
                        unique case (wr_data)
                            CMD_READ_ARRAY:   rd_mode <= RM_ARRAY;
                            CMD_READ_STATUS:  rd_mode <= RM_STATUS;
                            CMD_READ_ID:      rd_mode <= RM_ID;
                            CMD_CLEAR_STATUS: begin perr <= 1'b0; eerr <= 1'b0; end
                            CMD_CONFIRM: begin
                                state   <= S_EBUSY;
                                rd_mode <= RM_STATUS;
                            end
                            default: ;
                        endcase
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // output pulses toward the array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_prog  <= 1'b0;
            arr_erase <= 1'b0;
        end else begin
            arr_prog  <= (state == S_PBUSY) && tmr_zero;
            arr_erase <= (state == S_EBUSY) && tmr_zero && !susp_req;
        end
    end

    always_comb begin
        sts           = '0;
        sts[ST_READY] = !(state == S_PBUSY || state == S_EBUSY);
        sts[ST_SUSP]  = (state == S_ESUSP);
        sts[ST_EERR]  = eerr;
        sts[ST_PERR]  = perr;
    end

    assign arr_addr  = cap_addr;
    assign arr_wdata = cap_data;

    flash_rd_mux #(.DATA_W(DATA_W)) u_rdmux (
        .oe_n      (oe_n),
        .mode      (rd_mode),
        .id_sel    (addr[0]),
        .arr_rdata (arr_rdata),
        .sts       (sts),
        .mfr_code  (MFR_CODE),
        .dev_code  (DEV_CODE),
        .rdata     (rdata)
    );
endmodule

// File: rtl/flash_cmd_sva.sv
`timescale 1ns/1ps
module flash_cmd_sva
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arr_prog,
    input logic              arr_erase,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        sts,
    input op_state_t         state,
    input rd_mode_t          rd_mode
);
    p_reset_array_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_mode == RM_ARRAY && sts == 8'h80 && !arr_prog && !arr_erase));

    p_prog_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_prog |=> !arr_prog);

    p_pulse_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_prog || arr_erase) |-> sts[ST_READY]);

    p_erase_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |=> !arr_erase);

    p_no_dual_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_prog && arr_erase));

    p_susp_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sts[ST_SUSP] |-> sts[ST_READY]);

    p_busy_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PBUSY && $past(state == S_PBUSY)) |-> $stable(arr_addr));
endmodule

bind flash_cmd_fsm flash_cmd_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_prog  (arr_prog),
    .arr_erase (arr_erase),
    .arr_addr  (arr_addr),
    .sts       (sts),
    .state     (state),
    .rd_mode   (rd_mode)
);

// File: tb/flash_cmd_fsm_bench.sv
`timescale 1ns/1ps
module flash_cmd_fsm_bench;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 40;
    localparam logic [7:0] MFR = 8'hA7;
    localparam logic [7:0] DEV = 8'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_unlock = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       we_n = 1'b1, oe_n = 1'b1;
    logic [7:0] arr_rdata, rdata, arr_addr, arr_wdata;
    logic       arr_prog, arr_erase;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] mem     [0:255];
    logic [7:0] exp_mem [0:255];

    always #2.5 clk = ~clk;

    assign arr_rdata = mem[addr];

    flash_cmd_fsm #(.ADDR_W(8), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                    .BOOT_BLK(3), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_flash_cmd_fsm (
        .clk(clk), .rst_n(rst_n), .boot_unlock(boot_unlock), .addr(addr),
        .wdata(wdata), .we_n(we_n), .oe_n(oe_n), .arr_rdata(arr_rdata),
        .rdata(rdata), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_prog(arr_prog), .arr_erase(arr_erase)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // op: 0 idle, 1 program setup, 2 erase setup, 3 program busy, 4 erase busy, 5 suspended
    // mode: 0 array, 1 status, 2 identifier
    int         m_op = 0, m_mode = 0, m_cnt = 0;
    bit         m_perr = 0, m_eerr = 0, m_pp = 0, m_ep = 0, m_wprev = 1;
    logic [7:0] m_addr = '0, m_data = '0;

    always @(posedge clk) begin
        bit evt, lock;
        if (arr_prog) mem[arr_addr] = arr_wdata;
        if (arr_erase)
            for (int i = 0; i < 256; i++) if (i[7:6] == arr_addr[7:6]) mem[i] = 8'hFF;
        if (m_pp) exp_mem[m_addr] = m_data;
        if (m_ep)
            for (int i = 0; i < 256; i++) if (i[7:6] == m_addr[7:6]) exp_mem[i] = 8'hFF;
        if (!rst_n) begin
            m_op = 0; m_mode = 0; m_cnt = 0; m_perr = 0; m_eerr = 0;
            m_pp = 0; m_ep = 0; m_wprev = 1; m_addr = '0; m_data = '0;
        end else begin
            evt = we_n && !m_wprev;
            m_wprev = we_n;
            m_pp = 0; m_ep = 0;
            lock = (addr[7:6] == 2'd3) && !boot_unlock;
            case (m_op)
                0, 5: if (evt) begin
                    if (wdata == 8'hFF) m_mode = 0;
                    else if (wdata == 8'h70) m_mode = 1;
                    else if (wdata == 8'h90) m_mode = 2;
                    else if (wdata == 8'h50) begin m_perr = 0; m_eerr = 0; end
                    else if (m_op == 0 && wdata == 8'h40) m_op = 1;
                    else if (m_op == 0 && wdata == 8'h20) m_op = 2;
                    else if (m_op == 5 && wdata == 8'hD0) begin m_op = 4; m_mode = 1; end
                end
                1: if (evt) begin
                    m_mode = 1;
                    if (lock) begin m_perr = 1; m_op = 0; end
                    else begin m_addr = addr; m_data = wdata; m_op = 3; m_cnt = PROG_CYC - 1; end
                end
                2: if (evt) begin
                    m_mode = 1;
                    if (wdata != 8'hD0 || lock) begin m_eerr = 1; m_op = 0; end
                    else begin m_addr = addr; m_op = 4; m_cnt = ERASE_CYC - 1; end
                end
                3: if (m_cnt == 0) begin m_op = 0; m_pp = 1; end else m_cnt--;
                4: if (evt && wdata == 8'hB0) begin m_op = 5; m_mode = 1; end
                   else if (m_cnt == 0) begin m_op = 0; m_ep = 1; end
                   else m_cnt--;
                default: ;
            endcase
        end
    end

    function automatic logic [7:0] model_sts();
        return {!(m_op == 3 || m_op == 4), m_op == 5, m_eerr, m_perr, 4'b0};
    endfunction

    // compare every cycle just before the rising edge
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        #1.5;
        if (rst_n && !done) begin
            if (oe_n) exp_rd = 8'h00;
            else if (m_mode == 0) exp_rd = exp_mem[addr];
            else if (m_mode == 1) exp_rd = model_sts();
            else exp_rd = addr[0] ? DEV : MFR;
            check("R2 model rdata", rdata, exp_rd);
            check("R3 model arr_prog", {7'b0, arr_prog}, {7'b0, m_pp});
            check("R5 model arr_erase", {7'b0, arr_erase}, {7'b0, m_ep});
            if (m_pp || m_ep) check("R3 model arr_addr", arr_addr, m_addr);
            if (m_pp) check("R3 model arr_wdata", arr_wdata, m_data);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        oe_n = 1'b1; addr = a; wdata = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        addr = a; oe_n = 1'b0;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400; i++) begin
            oe_n = 1'b0;
            @(negedge clk);
            #1;
            if (rdata[7]) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        idle(3);
        #1 check("R1 rdata oe_n high in reset", rdata, 8'h00);
        check("R1 no prog pulse in reset", {7'b0, arr_prog}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h05, 8'h5F, "R1 array read after reset");

        wr(8'h00, 8'h70); rd(8'h00, 8'h80, "R2 status read idle");
        wr(8'h00, 8'h90); rd(8'h00, MFR, "R2 id byte 0"); rd(8'h01, DEV, "R2 id byte 1");
        wr(8'h00, 8'hFF); rd(8'h20, 8'h7A, "R2 array after FF");

        // program
        wr(8'h00, 8'h40); wr(8'h12, 8'h33);
        rd(8'h00, 8'h00, "R4 busy after program accept");
        wr(8'h20, 8'hFF);
        rd(8'h00, 8'h00, "R11 write during program ignored");
        wait_ready();
        rd(8'h00, 8'h80, "R4 ready after program");
        wr(8'h00, 8'hFF);
        rd(8'h12, 8'h33, "R3 programmed byte");
        rd(8'h20, 8'h7A, "R11 ignored write left other byte");

        // erase block 1
        wr(8'h40, 8'h20); wr(8'h40, 8'hD0);
        rd(8'h00, 8'h00, "R4 busy after erase accept");
        wait_ready();
        wr(8'h00, 8'hFF);
        rd(8'h45, 8'hFF, "R5 erased byte");
        rd(8'h12, 8'h33, "R5 other block untouched");

        // bad confirm
        wr(8'h05, 8'h20); wr(8'h05, 8'h77);
        rd(8'h00, 8'hA0, "R6 erase error status");
        wr(8'h00, 8'h50);
        rd(8'h00, 8'h80, "R9 clear status");
        wr(8'h00, 8'hFF);
        rd(8'h05, 8'h5F, "R6 no erase after bad confirm");

        // boot lock
        wr(8'h00, 8'h40); wr(8'hC1, 8'h55);
        rd(8'h00, 8'h90, "R7 locked program error");
        wr(8'h00, 8'h50);
        wr(8'hC0, 8'h20); wr(8'hC0, 8'hD0);
        rd(8'h00, 8'hA0, "R7 locked erase error");
        wr(8'h00, 8'h50);
        wr(8'h00, 8'hFF);
        rd(8'hC1, 8'h9B, "R7 locked byte unchanged");
        boot_unlock = 1'b1;
        wr(8'h00, 8'h40); wr(8'hC1, 8'h11);
        wait_ready();
        boot_unlock = 1'b0;
        wr(8'h00, 8'hFF);
        rd(8'hC1, 8'h11, "R7 unlocked program");

        // suspend / resume
        wr(8'h80, 8'h20); wr(8'h80, 8'hD0);
        idle(5);
        wr(8'h00, 8'hB0);
        rd(8'h00, 8'hC0, "R8 suspended status");
        wr(8'h00, 8'hFF);
        rd(8'h12, 8'h33, "R8 array read while suspended");
        rd(8'h85, 8'hDF, "R8 target not yet erased");
        idle(60);
        wr(8'h00, 8'h70);
        rd(8'h00, 8'hC0, "R8 still suspended");
        wr(8'h00, 8'hD0);
        rd(8'h00, 8'h00, "R8 busy after resume");
        wait_ready();
        wr(8'h00, 8'hFF);
        rd(8'h85, 8'hFF, "R8 erase completed after resume");

        // reset abort
        wr(8'h00, 8'h40); wr(8'h30, 8'h00);
        idle(2);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(PROG_CYC + 4);
        rd(8'h30, 8'h6A, "R10 aborted program left byte");
        wr(8'h00, 8'h70);
        rd(8'h00, 8'h80, "R10 ready after abort");

        oe_n = 1'b1;
        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule